// File: doc/BRIEF.md
# Byte-Addressed Profile and Window Loader

This block turns a narrow host write path into 32-bit words for two per-channel memories. The host first writes a 16-bit address register, which selects a channel and a byte address, and then writes one byte at a time to a data register. Each byte lands in a staging word at the lane named by the two lowest byte-address bits. When the most significant lane is written, the whole staged word is committed to one of two memories in a single write.

Byte-address bit 12 picks the memory. The profile memory holds, for each oscillator and profile, a frequency tuning word and an amplitude/phase word. The window memory holds window header words and the sample pairs that follow each header. Both memories have synchronous read ports for downstream playback logic. The window read port also shows the returned word split into its header fields.

Top module: `ldr_profile_window_loader`

## Requirements
- R1: A host write with `host_sel`=0 loads all 16 bits of `host_wdata` into the address register. Bits 15:13 hold the channel and bits 12:0 hold the byte address. Data writes never change the address register, so it does not auto-increment.
- R2: A host write with `host_sel`=1 carries one byte in `host_wdata[7:0]`. The byte is stored in the staging lane given by byte-address bits 1:0. Lane 0 is bits 7:0 and lane 3 is bits 31:24. The other lanes keep their contents.
- R3: Only a data write to lane 3 commits a word. The committed word is the new byte in bits 31:24 over staging bits 23:0, and all 32 bits are written at once. Writes to lanes 0 to 2 leave both memories unchanged.
- R4: When byte-address bit 12 is 1, the word goes to the profile memory at index {bits 11:8 oscillator, bits 7:3 profile, bit 2 select}. Select 0 is the frequency word. Select 1 is the amplitude/phase word, with amplitude in bits 15:0 and phase in bits 31:16. The window memory is not touched.
- R5: When byte-address bit 12 is 0, the word goes to the window memory at word index byte-address bits 11:2. The profile memory is not touched.
- R6: A data write is ignored when the address register's channel field differs from the CHANNEL parameter. Neither the staging word nor either memory changes.
- R7: Each read port returns the word at the address it presented one cycle earlier. The two ports work independently, and back-to-back reads are allowed every cycle.
- R8: Reset (synchronous, active high) clears the staging word to zero, and every location of both memories reads as zero until it is written again.
- R9: The window read port also presents its word as header fields: end address from bits 9:0, rate from bits 21:10 plus one (1 to 4096), shift from bits 27:22, order from bits 29:28, head flag from bit 30 and tail flag from bit 31.
- R10: A commit does not clear the staging word. After a commit, any lane that is not rewritten keeps its earlier byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = address register, 1 = data register |
| host_wdata | input | 16 | Host write data |
| prof_rd_addr | input | 10 | Profile read index {oscillator, profile, select} |
| prof_rd_data | output | 32 | Profile read data, one cycle after the address |
| win_rd_addr | input | 10 | Window read word index |
| win_rd_data | output | 32 | Window read data, one cycle after the address |
| win_hdr_end | output | 10 | Header end-address field of the window read data |
| win_hdr_rate | output | 13 | Header rate (field plus one) |
| win_hdr_shift | output | 6 | Header shift field |
| win_hdr_order | output | 2 | Header interpolation order |
| win_hdr_head | output | 1 | Header head flag |
| win_hdr_tail | output | 1 | Header tail flag |

## Verification
The bench goes after the points where byte steering can quietly corrupt a word:
- **Foreign-channel byte.** A byte for another channel arrives in the middle of an assembly. A design that staged it anyway would commit a word with a stray byte in lane 1.
- **Lane-3-only write.** A word is committed with only lane 3 written. This shows whether staging keeps its old lanes or was wrongly zeroed. After a second reset, the same test shows whether the reset actually cleared the staging word.
- **Bank separation.** Both memories are read at the same index after a write to one of them. This catches a decode that writes to both banks or to the wrong one.
- **Rate extremes.** Header words with rate fields of 0 and 4095 expose an off-by-one or a truncated rate output.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam int unsigned LANE_W  = $clog2(LANES);

  localparam int unsigned HDR_END_W   = 10;
  localparam int unsigned HDR_RATE_W  = 12;
  localparam int unsigned HDR_SHIFT_W = 6;
  localparam int unsigned HDR_ORDER_W = 2;

  // Bank select follows byte-address bit 12.
  typedef enum logic {
    BANK_WIN  = 1'b0,
    BANK_PROF = 1'b1
  } bank_e;

  // Window header layout, MSB first so that a cast matches the bit positions.
  typedef struct packed {
    logic                   tail;
    logic                   head;
    logic [HDR_ORDER_W-1:0] order;
    logic [HDR_SHIFT_W-1:0] shift;
    logic [HDR_RATE_W-1:0]  rate_m1;
    logic [HDR_END_W-1:0]   end_addr;
  } win_hdr_t;

endpackage

// File: rtl/ldr_host_if.sv
module ldr_host_if
  import ldr_pkg::*;
#(
  parameter  int unsigned CHAN_W  = 3,
  parameter  int unsigned CHANNEL = 0,
  parameter  int unsigned IDX_W   = 10,
  localparam int unsigned BADDR_W = IDX_W + 3,
  localparam int unsigned HOST_W  = CHAN_W + BADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic              cm_valid,
  output logic              cm_bank,
  output logic [IDX_W-1:0]  cm_idx,
  output logic [WORD_W-1:0] cm_data
);

  logic [HOST_W-1:0] addr_q;
  logic [WORD_W-1:0] stage_q;
  logic [CHAN_W-1:0] chan;
  logic [LANE_W-1:0] lane;
  logic              addr_wr;
  logic              data_wr;
  logic              hit;

  assign chan    = addr_q[HOST_W-1 -: CHAN_W];
  assign lane    = addr_q[LANE_W-1:0];
  assign addr_wr = host_we & ~host_sel;
  assign data_wr = host_we &  host_sel;
  assign hit     = data_wr && (chan == CHANNEL[CHAN_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (addr_wr) begin
      addr_q <= host_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (hit && (lane == LANE_W'(g))) begin
        stage_q[g*BYTE_W +: BYTE_W] <= host_wdata[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_valid <= 1'b0;
      cm_bank  <= 1'b0;
      cm_idx   <= '0;
      cm_data  <= '0;
    end else begin
      cm_valid <= hit && (lane == LANE_W'(LANES - 1));
      cm_bank  <= addr_q[BADDR_W-1];
      cm_idx   <= addr_q[BADDR_W-2:LANE_W];
      cm_data  <= {host_wdata[BYTE_W-1:0], stage_q[WORD_W-BYTE_W-1:0]};
    end
  end

  AST_ADDR_ONLY_ON_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(host_we && !host_sel) |=> $stable(addr_q)); // R1
  AST_STAGE_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    !(host_we && host_sel) |=> $stable(stage_q)); // R2
  AST_COMMIT_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> $past(host_we && host_sel)); // R3
  AST_COMMIT_LAST_LANE: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> ($past(addr_q[LANE_W-1:0]) == LANE_W'(LANES - 1))); // R3
  AST_CHAN_FILTER: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> ($past(addr_q[HOST_W-1 -: CHAN_W]) == CHANNEL[CHAN_W-1:0])); // R6

endmodule

// File: rtl/ldr_word_mem.sv
module ldr_word_mem #(
  parameter  int unsigned AW    = 10,
  parameter  int unsigned DW    = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0]    ram [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    rd_raw_q;
  logic             rd_vld_q;

  // Plain RAM, read-first, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      ram[wa] <= wd;
    end
    rd_raw_q <= ram[ra];
  end

  // Written-since-reset flags stand in for clearing the array.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      if (we) begin
        vld_q[wa] <= 1'b1;
      end
      rd_vld_q <= vld_q[ra];
    end
  end

  assign rd = rd_vld_q ? rd_raw_q : '0;

  AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (rst)
    we |=> vld_q[$past(wa)]); // R8
  AST_UNWRITTEN_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!vld_q[ra]) |-> (rd == '0)); // R8
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(!we) && $stable(ra)) |=> $stable(rd)); // R7

endmodule

// File: rtl/ldr_hdr_view.sv
module ldr_hdr_view
  import ldr_pkg::*;
(
  input  logic [WORD_W-1:0]      word,
  output logic [HDR_END_W-1:0]   end_addr,
  output logic [HDR_RATE_W:0]    rate,
  output logic [HDR_SHIFT_W-1:0] shift,
  output logic [HDR_ORDER_W-1:0] order,
  output logic                   head,
  output logic                   tail
);

  win_hdr_t hdr;

  assign hdr      = win_hdr_t'(word);
  assign end_addr = hdr.end_addr;
  assign rate     = {1'b0, hdr.rate_m1} + (HDR_RATE_W+1)'(1);
  assign shift    = hdr.shift;
  assign order    = hdr.order;
  assign head     = hdr.head;
  assign tail     = hdr.tail;

endmodule

// File: rtl/ldr_profile_window_loader.sv
module ldr_profile_window_loader
  import ldr_pkg::*;
#(
  parameter  int unsigned CHAN_W  = 3,
  parameter  int unsigned CHANNEL = 0,
  parameter  int unsigned OSC_W   = 4,
  parameter  int unsigned PROF_W  = 5,
  localparam int unsigned IDX_W   = OSC_W + PROF_W + 1,
  localparam int unsigned HOST_W  = CHAN_W + IDX_W + 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_we,
  input  logic                   host_sel,
  input  logic [HOST_W-1:0]      host_wdata,
  input  logic [IDX_W-1:0]       prof_rd_addr,
  output logic [WORD_W-1:0]      prof_rd_data,
  input  logic [IDX_W-1:0]       win_rd_addr,
  output logic [WORD_W-1:0]      win_rd_data,
  output logic [HDR_END_W-1:0]   win_hdr_end,
  output logic [HDR_RATE_W:0]    win_hdr_rate,
  output logic [HDR_SHIFT_W-1:0] win_hdr_shift,
  output logic [HDR_ORDER_W-1:0] win_hdr_order,
  output logic                   win_hdr_head,
  output logic                   win_hdr_tail
);

  logic              cm_valid;
  logic              cm_bank;
  logic [IDX_W-1:0]  cm_idx;
  logic [WORD_W-1:0] cm_data;
  logic [IDX_W-1:0]  bank_ra [2];
  logic [WORD_W-1:0] bank_rd [2];

  ldr_host_if #(
    .CHAN_W  (CHAN_W),
    .CHANNEL (CHANNEL),
    .IDX_W   (IDX_W)
  ) u_host (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .cm_valid   (cm_valid),
    .cm_bank    (cm_bank),
    .cm_idx     (cm_idx),
    .cm_data    (cm_data)
  );

  assign bank_ra[BANK_WIN]  = win_rd_addr;
  assign bank_ra[BANK_PROF] = prof_rd_addr;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ldr_word_mem #(
      .AW (IDX_W),
      .DW (WORD_W)
    ) u_mem (
      .clk (clk),
      .rst (rst),
      .we  (cm_valid && (cm_bank == 1'(b))),
      .wa  (cm_idx),
      .wd  (cm_data),
      .ra  (bank_ra[b]),
      .rd  (bank_rd[b])
    );
  end

  assign win_rd_data  = bank_rd[BANK_WIN];
  assign prof_rd_data = bank_rd[BANK_PROF];

  ldr_hdr_view u_hdr (
    .word     (win_rd_data),
    .end_addr (win_hdr_end),
    .rate     (win_hdr_rate),
    .shift    (win_hdr_shift),
    .order    (win_hdr_order),
    .head     (win_hdr_head),
    .tail     (win_hdr_tail)
  );

  AST_ONE_BANK_PER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_bank[0].u_mem.we, g_bank[1].u_mem.we})); // R4

endmodule

// File: tb/tb_ldr_profile_window_loader.sv
module tb_ldr_profile_window_loader;

  localparam int CHAN = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic        host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [9:0]  prof_rd_addr = '0;
  logic [31:0] prof_rd_data;
  logic [9:0]  win_rd_addr = '0;
  logic [31:0] win_rd_data;
  logic [9:0]  win_hdr_end;
  logic [12:0] win_hdr_rate;
  logic [5:0]  win_hdr_shift;
  logic [1:0]  win_hdr_order;
  logic        win_hdr_head;
  logic        win_hdr_tail;

  always #5 clk = ~clk;

  ldr_profile_window_loader dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .prof_rd_addr(prof_rd_addr),
    .prof_rd_data(prof_rd_data), .win_rd_addr(win_rd_addr),
    .win_rd_data(win_rd_data), .win_hdr_end(win_hdr_end),
    .win_hdr_rate(win_hdr_rate), .win_hdr_shift(win_hdr_shift),
    .win_hdr_order(win_hdr_order), .win_hdr_head(win_hdr_head),
    .win_hdr_tail(win_hdr_tail)
  );

  typedef struct {
    bit          win;
    logic [31:0] exp;
    string       req;
    int          due;
  } item_t;

  item_t       sbq[$];
  logic [31:0] prof_m [1024];
  logic [31:0] win_m  [1024];
  logic [31:0] stg;
  logic [15:0] areg;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 1024; i++) begin
      prof_m[i] = '0;
      win_m[i]  = '0;
    end
    stg  = '0;
    areg = '0;
  endtask

  task automatic host_wr(bit sel, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    if (!sel) areg = d;
    else if (areg[15:13] == 3'(CHAN)) begin
      stg[8*areg[1:0] +: 8] = d[7:0];
      if (areg[1:0] == 2'd3) begin
        if (areg[12]) prof_m[areg[11:2]] = stg;
        else          win_m[areg[11:2]]  = stg;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic write32(logic [2:0] ch, logic [12:0] baddr, logic [31:0] w);
    for (int i = 0; i < 4; i++) begin
      host_wr(1'b0, {ch, 13'(baddr + 13'(i))});
      host_wr(1'b1, {8'h00, w[8*i +: 8]});
    end
    idle();
  endtask

  task automatic rd(bit win, logic [9:0] idx, string req);
    item_t it;
    @(negedge clk);
    host_we = 1'b0;
    if (win) win_rd_addr = idx; else prof_rd_addr = idx;
    it.win = win; it.exp = win ? win_m[idx] : prof_m[idx]; it.req = req; it.due = cyc + 1;
    sbq.push_back(it);
  endtask

  task automatic rd_both(logic [9:0] pidx, logic [9:0] widx, string req);
    item_t a;
    item_t b;
    @(negedge clk);
    host_we = 1'b0;
    prof_rd_addr = pidx; win_rd_addr = widx;
    a.win = 1'b0; a.exp = prof_m[pidx]; a.req = req; a.due = cyc + 1;
    b.win = 1'b1; b.exp = win_m[widx];  b.req = req; b.due = cyc + 1;
    sbq.push_back(a);
    sbq.push_back(b);
  endtask

  task automatic do_reset();
    wait (sbq.size() == 0);
    @(negedge clk);
    host_we = 1'b0; rst = 1'b1;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
        it = sbq.pop_front();
        if (!it.win) begin
          chk(prof_rd_data === it.exp, it.req, "profile read", prof_rd_data, it.exp);
        end else begin
          chk(win_rd_data === it.exp, it.req, "window read", win_rd_data, it.exp);
          chk(win_hdr_end === it.exp[9:0], "R9", "hdr end", 32'(win_hdr_end), 32'(it.exp[9:0]));
          chk(win_hdr_rate === 13'({1'b0, it.exp[21:10]} + 13'd1), "R9", "hdr rate",
              32'(win_hdr_rate), 32'({1'b0, it.exp[21:10]} + 13'd1));
          chk({win_hdr_tail, win_hdr_head, win_hdr_order, win_hdr_shift} === it.exp[31:22],
              "R9", "hdr flags", 32'({win_hdr_tail, win_hdr_head, win_hdr_order, win_hdr_shift}),
              32'(it.exp[31:22]));
        end
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'(cyc), 32'(0));
    finish_run();
  end

  initial begin
    logic [31:0] hdr;
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8: everything reads zero after reset
    rd(1'b0, 10'd0, "R8");
    rd(1'b0, 10'd1023, "R8");
    rd(1'b1, 10'd0, "R8");
    rd(1'b1, 10'd1023, "R8");

    // R3 R4: frequency and amplitude/phase words, osc 3, profile 7
    write32(3'(CHAN), 13'h1338, 32'hDEADBEEF);
    write32(3'(CHAN), 13'h133C, 32'h1234ABCD);
    rd(1'b0, 10'h0CE, "R4");
    rd(1'b0, 10'h0CF, "R4");
    rd(1'b1, 10'h0CE, "R4");
    rd(1'b1, 10'h0CF, "R4");

    // R5 R9: header then samples at window words 0..5
    hdr = {1'b0, 1'b1, 2'd3, 6'd5, 12'd4095, 10'd6};
    write32(3'(CHAN), 13'h0000, hdr);
    for (int i = 1; i < 6; i++) write32(3'(CHAN), 13'(4 * i), {16'(i * 3), 16'(16'hF000 + i)});
    for (int i = 0; i < 6; i++) rd(1'b1, 10'(i), "R5");
    rd(1'b0, 10'd0, "R5");
    rd(1'b0, 10'd1, "R5");

    // R9: minimum rate field, tail set
    write32(3'(CHAN), 13'h0800, {1'b1, 1'b0, 2'd1, 6'd63, 12'd0, 10'd1023});
    rd(1'b1, 10'd512, "R9");

    // R6: other channel word ignored
    write32(3'd3, 13'h0004, 32'h55AA55AA);
    write32(3'd2, 13'h1338, 32'h0BADF00D);
    rd(1'b1, 10'd1, "R6");
    rd(1'b0, 10'h0CE, "R6");

    // R6: foreign byte mid-assembly does not reach staging
    host_wr(1'b0, {3'(CHAN), 13'h0050}); host_wr(1'b1, 16'h0011);
    host_wr(1'b0, {3'(CHAN), 13'h0051}); host_wr(1'b1, 16'h0022);
    host_wr(1'b0, {3'(CHAN), 13'h0052}); host_wr(1'b1, 16'h0033);
    host_wr(1'b0, {3'd5,     13'h0051}); host_wr(1'b1, 16'h0077);
    host_wr(1'b0, {3'(CHAN), 13'h0053}); host_wr(1'b1, 16'h0044);
    idle();
    rd(1'b1, 10'd20, "R6");

    // R1 R3: address does not advance; lane-0 writes do not commit
    host_wr(1'b0, {3'(CHAN), 13'h0060});
    host_wr(1'b1, 16'hFF91);
    host_wr(1'b1, 16'h0092);
    idle();
    rd(1'b1, 10'd24, "R3");
    host_wr(1'b0, {3'(CHAN), 13'h0063});
    host_wr(1'b1, 16'h00A5);
    idle();
    rd(1'b1, 10'd24, "R1");

    // R10: lane-3-only write reuses prior staging lanes
    host_wr(1'b0, {3'(CHAN), 13'h007B});
    host_wr(1'b1, 16'h00C3);
    idle();
    rd(1'b1, 10'd30, "R10");

    // R7: back-to-back dual-port reads
    for (int i = 0; i < 6; i++) rd_both(10'h0CE + 10'(i & 1), 10'(5 - i), "R7");

    // R8: second reset clears memories and staging
    do_reset();
    rd(1'b1, 10'd1, "R8");
    rd(1'b0, 10'h0CE, "R8");
    host_wr(1'b0, {3'(CHAN), 13'h1007});
    host_wr(1'b1, 16'h005E);
    idle();
    rd(1'b0, 10'd1, "R8");

    wait (sbq.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule